// File: doc/BRIEF.md
# Guarded On-Chip Memory Controller

This controller sits between a processor bus and a 16-Kbyte block of on-chip storage. Each transfer arrives as a one-cycle request pulse. The request carries a byte address, a write flag, an instruction-fetch flag and a privilege flag. The controller answers with either a ready pulse or a transfer-error pulse, and a read answer also carries data. The storage is split into four 4-Kbyte regions, and each region has its own access policy. An access that breaks a policy is refused with an error and has no side effect.

A 32-bit configuration word sits behind a separate select input. It holds the per-region policy bits, a module-disable bit, a timing-mode bit and a lock bit. Once the lock bit is set, the configuration word is frozen until reset. In the slow timing mode, an array access uses one cycle to decode the address and a second cycle to move the data. Configuration accesses always finish in one cycle.

Bit positions below are vector indices of `cfg[31:0]`, where index 31 is the most significant bit.

Top module: `psram_ctrl`

## Requirements
- R1: After reset every configuration bit is 0, so a configuration read returns 0x00000000. The module is enabled, unlocked and in single-cycle timing, with no region restricted. During reset `acc_ready` and `acc_err` are low.
- R2: In single-cycle timing, the ready or error pulse of an array access appears in the cycle after the request pulse. A read returns the word most recently written at that word address (address bits [13:2]).
- R3: Index 29 set selects two-cycle timing. The array-access response then appears two cycles after the request pulse. Configuration reads and writes still respond one cycle after their pulse.
- R4: Region r is read-only when index 11-3r is set. A write to it gives an error, and the stored word keeps its old value. Reads of that region succeed.
- R5: Region r is data-only when index 10-3r is set. An instruction fetch from it gives an error, and a data read of the same word succeeds. The fetch flag is ignored on writes.
- R6: Region r is supervisor-only when index 9-3r is set. A user-level read or write there gives an error. The same access at supervisor level succeeds.
- R7: Index 30 set disables the module. Every array read and fetch then gives an error, while array writes still complete and store their data. Configuration reads still work, and writing index 30 back to 0 re-enables reads.
- R8: Index 31 is the lock. Once it is set, every configuration write still answers ready but changes nothing, and the word can still be read. Only reset clears the lock.
- R9: Indices 28 down to 12 are reserved. They read as 0 whatever value is written to them.
- R10: Address bits [13:12] select the region, with region 0 at the lowest addresses. A policy on region 1 affects address 0x1000 but not 0x0FFC.
- R11: An error pulse takes the place of the ready pulse in the same cycle, and the two are never high together. Each response lasts one cycle. `acc_rdata` is 0 except during the ready pulse of a read. An access that breaks several policies at once gives one error and still has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle request pulse |
| cfg_sel | input | 1 | Request targets the configuration word instead of the array |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | Read is an instruction fetch |
| acc_super | input | 1 | 1 = supervisor level, 0 = user level |
| acc_addr | input | 14 | Byte address into the array |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Access completed |
| acc_err | output | 1 | Access refused (transfer error) |
| acc_rdata | output | 32 | Read data, valid with acc_ready on reads |

## Verification
The bench checks the lock on a write that would have cleared every policy and the timing bit. A lock that did not hold would make the next array access answer in one cycle instead of two. It checks the region edge at 0x0FFC versus 0x1000: a region decode off by one bit would refuse or accept the wrong word. It follows each refused write with a read of the same word, so a design that writes before deciding shows the changed word. It also times configuration accesses in two-cycle mode, a disabled-module write and a doubly illegal access. A wrong design would stretch the configuration access to two cycles, refuse the write, or give two error pulses.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int CFG_W   = 32;
    localparam int LOCK_IX = 31;
    localparam int DIS_IX  = 30;
    localparam int TWO_IX  = 29;
    localparam int MAX_RGN = 4;

    // Per-region policy bit positions (vector index, 31 = MSB)
    function automatic int ro_ix(input int r);
        return 11 - 3 * r;
    endfunction

    function automatic int do_ix(input int r);
        return 10 - 3 * r;
    endfunction

    function automatic int su_ix(input int r);
        return 9 - 3 * r;
    endfunction

    function automatic logic [CFG_W-1:0] writable_mask();
        logic [CFG_W-1:0] m;
        m = '0;
        m[LOCK_IX] = 1'b1;
        m[DIS_IX]  = 1'b1;
        m[TWO_IX]  = 1'b1;
        for (int r = 0; r < MAX_RGN; r++) begin
            m[ro_ix(r)] = 1'b1;
            m[do_ix(r)] = 1'b1;
            m[su_ix(r)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [CFG_W-1:0] CFG_WMASK = writable_mask();

endpackage

// File: rtl/psram_cfg_reg.sv
module psram_cfg_reg
    import psram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_o
);

    typedef struct packed {
        logic [CFG_W-1:0] bits;
    } cfg_st_t;

    cfg_st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en && !r_q.bits[LOCK_IX]) begin
            r_d.bits = wr_data & CFG_WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_o = r_q.bits;

    // Once locked, the word never changes again until reset
    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.bits[LOCK_IX] |=> ($stable(r_q.bits) && r_q.bits[LOCK_IX]));

endmodule

// File: rtl/psram_policy.sv
module psram_policy
    import psram_pkg::*;
#(
    parameter int REGION_BITS = 2
) (
    input  logic [CFG_W-1:0]       cfg,
    input  logic [REGION_BITS-1:0] region,
    input  logic                   is_write,
    input  logic                   is_fetch,
    input  logic                   is_priv,
    output logic                   violation
);

    localparam int REGIONS = 1 << REGION_BITS;

    logic [REGIONS-1:0] ro_v, do_v, su_v;

    for (genvar r = 0; r < REGIONS; r++) begin : g_rgn
        assign ro_v[r] = cfg[ro_ix(r)];
        assign do_v[r] = cfg[do_ix(r)];
        assign su_v[r] = cfg[su_ix(r)];
    end

    logic hit_dis, hit_ro, hit_do, hit_su;

    always_comb begin
        hit_dis   = cfg[DIS_IX] && !is_write;
        hit_ro    = ro_v[region] && is_write;
        hit_do    = do_v[region] && is_fetch && !is_write;
        hit_su    = su_v[region] && !is_priv;
        violation = hit_dis || hit_ro || hit_do || hit_su;
    end

endmodule

// File: rtl/psram_store.sv
module psram_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 12
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] cells [WORDS];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) cells[idx] <= wr_data;
        if (rd_en) rd_q <= cells[idx];
    end

    assign rd_data = rd_q;

    // A word is never read and written in the same cycle
    assert_port_exclusive_R11: assert property (@(posedge clk)
        !(wr_en && rd_en));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 32,
    parameter int REGION_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              cfg_sel,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_super,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_ready,
    output logic              acc_err,
    output logic [DATA_W-1:0] acc_rdata
);

    localparam int LANE_W = $clog2(DATA_W / 8);
    localparam int IDX_W  = ADDR_W - LANE_W;

    typedef struct packed {
        logic              write;
        logic              fetch;
        logic              priv;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef enum logic {PH_IDLE = 1'b0, PH_DATA = 1'b1} phase_e;

    typedef struct packed {
        phase_e            phase;
        req_t              held;
        logic              ready;
        logic              err;
        logic              rd_resp;
        logic              rd_cfg;
        logic [DATA_W-1:0] cfg_snap;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [CFG_W-1:0]       cfg_w;
    logic                   cfg_we;
    req_t                   in_req, ex_req;
    logic                   cfg_acc, arr_new, exec_arr, two_mode;
    logic                   viol, mem_we, mem_re;
    logic [DATA_W-1:0]      mem_rdata;
    logic [REGION_BITS-1:0] ex_region;
    logic                   unused_lane_bits;

    assign unused_lane_bits = ^acc_addr[LANE_W-1:0];

    // Request selection: live inputs, or the request held for its data phase
    always_comb begin
        in_req    = '{write: acc_write, fetch: acc_fetch, priv: acc_super,
                      idx: acc_addr[ADDR_W-1:LANE_W], wdata: acc_wdata};
        two_mode  = cfg_w[TWO_IX];
        cfg_acc   = acc_valid && cfg_sel && (c_q.phase == PH_IDLE);
        arr_new   = acc_valid && !cfg_sel && (c_q.phase == PH_IDLE);
        exec_arr  = (arr_new && !two_mode) || (c_q.phase == PH_DATA);
        ex_req    = (c_q.phase == PH_DATA) ? c_q.held : in_req;
        ex_region = ex_req.idx[IDX_W-1 -: REGION_BITS];
    end

    psram_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (acc_wdata[CFG_W-1:0]),
        .cfg_o   (cfg_w)
    );

    psram_policy #(.REGION_BITS(REGION_BITS)) u_policy (
        .cfg       (cfg_w),
        .region    (ex_region),
        .is_write  (ex_req.write),
        .is_fetch  (ex_req.fetch),
        .is_priv   (ex_req.priv),
        .violation (viol)
    );

    psram_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .wr_en   (mem_we),
        .rd_en   (mem_re),
        .idx     (ex_req.idx),
        .wr_data (ex_req.wdata),
        .rd_data (mem_rdata)
    );

    // Next-state computation
    always_comb begin
        c_d         = c_q;
        c_d.ready   = 1'b0;
        c_d.err     = 1'b0;
        c_d.rd_resp = 1'b0;
        c_d.rd_cfg  = 1'b0;
        cfg_we      = 1'b0;
        mem_we      = 1'b0;
        mem_re      = 1'b0;

        if (cfg_acc) begin
            c_d.ready    = 1'b1;
            c_d.rd_resp  = !acc_write;
            c_d.rd_cfg   = 1'b1;
            c_d.cfg_snap = DATA_W'(cfg_w);
            cfg_we       = acc_write;
        end

        if (arr_new && two_mode) begin
            c_d.phase = PH_DATA;
            c_d.held  = in_req;
        end

        if (exec_arr) begin
            c_d.phase = PH_IDLE;
            if (viol) begin
                c_d.err = 1'b1;
            end else begin
                c_d.ready   = 1'b1;
                c_d.rd_resp = !ex_req.write;
                mem_we      = ex_req.write;
                mem_re      = !ex_req.write;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign acc_ready = c_q.ready;
    assign acc_err   = c_q.err;
    assign acc_rdata = c_q.rd_resp ? (c_q.rd_cfg ? c_q.cfg_snap : mem_rdata) : '0;

    // Policy bits looked up straight from the configuration word
    logic chk_ro, chk_do, chk_su;
    always_comb begin
        chk_ro = cfg_w[ro_ix(int'(ex_region))];
        chk_do = cfg_w[do_ix(int'(ex_region))];
        chk_su = cfg_w[su_ix(int'(ex_region))];
    end

    assert_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((arr_new && !two_mode) || cfg_acc) |=> (acc_ready || acc_err));

    assert_decode_phase_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_new && two_mode) |=> (!acc_ready && !acc_err));

    assert_data_phase_answers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.phase == PH_DATA) |=> (acc_ready || acc_err));

    assert_ro_write_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_arr && ex_req.write && chk_ro) |=> (acc_err && !acc_ready));

    assert_do_fetch_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_arr && ex_req.fetch && !ex_req.write && chk_do) |=> acc_err);

    assert_user_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_arr && !ex_req.priv && chk_su) |=> acc_err);

    assert_disabled_read_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_arr && !ex_req.write && cfg_w[DIS_IX]) |=> acc_err);

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_ready && acc_err));

endmodule

// File: tb/psram_ctrl_test.sv
module psram_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        acc_super = 1'b0;
    logic [13:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ready, acc_err;
    logic [31:0] acc_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    psram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .cfg_sel(cfg_sel),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_super(acc_super),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_ready(acc_ready), .acc_err(acc_err), .acc_rdata(acc_rdata)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        sel;
        logic        wr;
        logic        fe;
        logic        su;
        logic [13:0] addr;
        logic [31:0] wdata;
        logic        err;
        logic [31:0] rd;
        logic [1:0]  lat;
    } vec_t;

    localparam int NV = 37;
    // fields: req, sel, wr, fetch, super, addr, wdata, expect-err, expect-rdata, latency
    localparam vec_t VEC [NV] = '{
        '{4'd2,  1'b0,1'b1,1'b0,1'b1, 14'h0004, 32'hA1A1_0001, 1'b0, 32'h0,           2'd1}, // R2
        '{4'd2,  1'b0,1'b1,1'b0,1'b1, 14'h1008, 32'hB2B2_0002, 1'b0, 32'h0,           2'd1}, // R2
        '{4'd2,  1'b0,1'b1,1'b0,1'b1, 14'h2010, 32'hC3C3_0003, 1'b0, 32'h0,           2'd1}, // R2
        '{4'd2,  1'b0,1'b1,1'b0,1'b1, 14'h3FFC, 32'hD4D4_0004, 1'b0, 32'h0,           2'd1}, // R2
        '{4'd2,  1'b0,1'b0,1'b0,1'b1, 14'h0004, 32'h0,         1'b0, 32'hA1A1_0001,   2'd1}, // R2
        '{4'd2,  1'b0,1'b0,1'b0,1'b0, 14'h3FFC, 32'h0,         1'b0, 32'hD4D4_0004,   2'd1}, // R2
        '{4'd9,  1'b1,1'b1,1'b0,1'b0, 14'h0,    32'h1FFF_F111, 1'b0, 32'h0,           2'd1}, // R9
        '{4'd9,  1'b1,1'b0,1'b0,1'b0, 14'h0,    32'h0,         1'b0, 32'h0000_0111,   2'd1}, // R9
        '{4'd4,  1'b0,1'b1,1'b0,1'b1, 14'h1008, 32'hDEAD_BEEF, 1'b1, 32'h0,           2'd1}, // R4
        '{4'd4,  1'b0,1'b0,1'b0,1'b1, 14'h1008, 32'h0,         1'b0, 32'hB2B2_0002,   2'd1}, // R4
        '{4'd10, 1'b0,1'b1,1'b0,1'b1, 14'h0008, 32'hE5E5_0005, 1'b0, 32'h0,           2'd1}, // R10
        '{4'd5,  1'b0,1'b0,1'b1,1'b1, 14'h2010, 32'h0,         1'b1, 32'h0,           2'd1}, // R5
        '{4'd5,  1'b0,1'b0,1'b0,1'b1, 14'h2010, 32'h0,         1'b0, 32'hC3C3_0003,   2'd1}, // R5
        '{4'd5,  1'b0,1'b0,1'b1,1'b1, 14'h0004, 32'h0,         1'b0, 32'hA1A1_0001,   2'd1}, // R5
        '{4'd6,  1'b0,1'b0,1'b0,1'b0, 14'h3FFC, 32'h0,         1'b1, 32'h0,           2'd1}, // R6
        '{4'd6,  1'b0,1'b1,1'b0,1'b0, 14'h3FFC, 32'h1111_1111, 1'b1, 32'h0,           2'd1}, // R6
        '{4'd6,  1'b0,1'b0,1'b0,1'b1, 14'h3FFC, 32'h0,         1'b0, 32'hD4D4_0004,   2'd1}, // R6
        '{4'd10, 1'b0,1'b0,1'b0,1'b0, 14'h0008, 32'h0,         1'b0, 32'hE5E5_0005,   2'd1}, // R10
        '{4'd7,  1'b1,1'b1,1'b0,1'b0, 14'h0,    32'h4000_0111, 1'b0, 32'h0,           2'd1}, // R7
        '{4'd7,  1'b0,1'b0,1'b0,1'b1, 14'h0004, 32'h0,         1'b1, 32'h0,           2'd1}, // R7
        '{4'd7,  1'b0,1'b0,1'b1,1'b1, 14'h0004, 32'h0,         1'b1, 32'h0,           2'd1}, // R7
        '{4'd7,  1'b0,1'b1,1'b0,1'b1, 14'h000C, 32'hF6F6_0006, 1'b0, 32'h0,           2'd1}, // R7
        '{4'd7,  1'b1,1'b0,1'b0,1'b0, 14'h0,    32'h0,         1'b0, 32'h4000_0111,   2'd1}, // R7
        '{4'd7,  1'b1,1'b1,1'b0,1'b0, 14'h0,    32'h0,         1'b0, 32'h0,           2'd1}, // R7
        '{4'd7,  1'b0,1'b0,1'b0,1'b1, 14'h000C, 32'h0,         1'b0, 32'hF6F6_0006,   2'd1}, // R7
        '{4'd3,  1'b1,1'b1,1'b0,1'b0, 14'h0,    32'h2000_0100, 1'b0, 32'h0,           2'd1}, // R3
        '{4'd3,  1'b0,1'b0,1'b0,1'b1, 14'h0004, 32'h0,         1'b0, 32'hA1A1_0001,   2'd2}, // R3
        '{4'd3,  1'b0,1'b1,1'b0,1'b1, 14'h1000, 32'h0000_0077, 1'b1, 32'h0,           2'd2}, // R3
        '{4'd3,  1'b1,1'b0,1'b0,1'b0, 14'h0,    32'h0,         1'b0, 32'h2000_0100,   2'd1}, // R3
        '{4'd3,  1'b0,1'b1,1'b0,1'b1, 14'h2000, 32'h0789_ABCD, 1'b0, 32'h0,           2'd2}, // R3
        '{4'd3,  1'b0,1'b0,1'b0,1'b1, 14'h2000, 32'h0,         1'b0, 32'h0789_ABCD,   2'd2}, // R3
        '{4'd8,  1'b1,1'b1,1'b0,1'b0, 14'h0,    32'hA000_0000, 1'b0, 32'h0,           2'd1}, // R8
        '{4'd8,  1'b1,1'b1,1'b0,1'b0, 14'h0,    32'h0000_0000, 1'b0, 32'h0,           2'd1}, // R8
        '{4'd8,  1'b1,1'b0,1'b0,1'b0, 14'h0,    32'h0,         1'b0, 32'hA000_0000,   2'd1}, // R8
        '{4'd8,  1'b0,1'b0,1'b0,1'b1, 14'h1008, 32'h0,         1'b0, 32'hB2B2_0002,   2'd2}, // R8
        '{4'd8,  1'b1,1'b1,1'b0,1'b0, 14'h0,    32'h4000_0000, 1'b0, 32'h0,           2'd1}, // R8
        '{4'd8,  1'b0,1'b0,1'b0,1'b1, 14'h0004, 32'h0,         1'b0, 32'hA1A1_0001,   2'd2}  // R8
    };

    task automatic check(input bit ok, input int req, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s", req, what);
        end
    endtask

    // Called right after a falling edge; returns right after a falling edge.
    task automatic expect_acc(input int req, input logic sel, input logic wr,
                              input logic fe, input logic su, input logic [13:0] addr,
                              input logic [31:0] wdata, input logic exp_err,
                              input logic [31:0] exp_rd, input int exp_lat);
        int lat;
        logic g_rdy, g_err;
        logic [31:0] g_rd;
        acc_valid = 1'b1; cfg_sel = sel; acc_write = wr; acc_fetch = fe;
        acc_super = su; acc_addr = addr; acc_wdata = wdata;
        @(negedge clk);
        acc_valid = 1'b0;
        lat = 1;
        while (!(acc_ready || acc_err) && lat < 4) begin
            @(negedge clk);
            lat++;
        end
        g_rdy = acc_ready; g_err = acc_err; g_rd = acc_rdata;
        check(g_rdy == !exp_err && g_err == exp_err && g_rd == exp_rd && lat == exp_lat, req,
              $sformatf("addr=%h: actual rdy=%b err=%b rdata=%h lat=%0d expected rdy=%b err=%b rdata=%h lat=%0d",
                        addr, g_rdy, g_err, g_rd, lat, !exp_err, exp_err, exp_rd, exp_lat));
        @(negedge clk);
        // R11: response lasts exactly one cycle
        check(!acc_ready && !acc_err && acc_rdata == 32'h0, 11,
              $sformatf("pulse length addr=%h: actual rdy=%b err=%b rdata=%h expected 0 0 0",
                        addr, acc_ready, acc_err, acc_rdata));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet while in reset
        repeat (3) @(negedge clk);
        check(!acc_ready && !acc_err && acc_rdata == 32'h0, 1,
              $sformatf("in reset: actual rdy=%b err=%b rdata=%h expected 0 0 0",
                        acc_ready, acc_err, acc_rdata));
        rst_n = 1'b1;
        @(negedge clk);
        // R1: configuration word is zero after reset
        expect_acc(1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0, 32'h0, 1'b0, 32'h0, 1);

        for (int i = 0; i < NV; i++) begin
            expect_acc(int'(VEC[i].req), VEC[i].sel, VEC[i].wr, VEC[i].fe, VEC[i].su,
                       VEC[i].addr, VEC[i].wdata, VEC[i].err, VEC[i].rd, int'(VEC[i].lat));
        end

        // R1: reset in the middle of a locked, two-cycle configuration
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!acc_ready && !acc_err, 1,
              $sformatf("second reset: actual rdy=%b err=%b expected 0 0", acc_ready, acc_err));
        rst_n = 1'b1;
        @(negedge clk);
        expect_acc(1, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0, 32'h0, 1'b0, 32'h0, 1);
        expect_acc(1, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0004, 32'h0, 1'b0, 32'hA1A1_0001, 1);

        // R8: lock cleared by reset, the word is writable again
        expect_acc(8, 1'b1, 1'b1, 1'b0, 1'b0, 14'h0, 32'h0000_0007, 1'b0, 32'h0, 1);
        expect_acc(8, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0, 32'h0, 1'b0, 32'h0000_0007, 1);

        // R11: user write to a read-only, supervisor-only region: one error, no change
        expect_acc(11, 1'b0, 1'b1, 1'b0, 1'b0, 14'h3FFC, 32'h5555_5555, 1'b1, 32'h0, 1);
        expect_acc(11, 1'b0, 1'b0, 1'b0, 1'b1, 14'h3FFC, 32'h0, 1'b0, 32'hD4D4_0004, 1);
        // R5: supervisor fetch from a data-only region
        expect_acc(5, 1'b0, 1'b0, 1'b1, 1'b1, 14'h3FFC, 32'h0, 1'b1, 32'h0, 1);

        // R10: region edge between 0x0FFC and 0x1000 with region 1 read-only
        expect_acc(10, 1'b1, 1'b1, 1'b0, 1'b0, 14'h0, 32'h0000_0100, 1'b0, 32'h0, 1);
        expect_acc(10, 1'b0, 1'b1, 1'b0, 1'b1, 14'h0FFC, 32'h0F0F_0F0F, 1'b0, 32'h0, 1);
        expect_acc(10, 1'b0, 1'b1, 1'b0, 1'b1, 14'h1000, 32'h1234_5678, 1'b1, 32'h0, 1);
        expect_acc(10, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0FFC, 32'h0, 1'b0, 32'h0F0F_0F0F, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule